// File: doc/BRIEF.md
# Serial Port FIFO Register and Status Controller

This block is the register-side logic that sits between a byte-wide register bus and the transmit and receive queues of a serial port. Software sees eight-bit registers: a FIFO parameter register that reports each queue's depth as an exponent code and holds the two queue-enable bits, a FIFO control register with self-clearing flush bits and interrupt enables, a FIFO status register, transmit and receive watermarks, transmit and receive fill counts, a line status register and the data register. Writes to the data register feed the transmit queue. Reads of the data register drain the receive queue.

Toward the serial side the block offers two streams. The transmit stream is valid/ready: `tx_valid` is high whenever the transmit queue holds a byte, `tx_data` is the oldest byte, and a byte leaves on any rising edge where `tx_valid` and `tx_ready` are both high. The shifter may hold `tx_ready` low for as long as it likes. The receive stream has no back-pressure, because a serial line cannot be paused. A byte with `rx_valid` high is taken on that edge if there is room. If there is no room it is lost and the overrun is flagged. Each received byte carries three error bits, which travel through the queue with it.

The data-ready flags are set by programmable watermarks. The sticky line errors clear only through a status read followed by a data read. Each queue's depth is 2^(code+1), with the code set by a parameter.

Top module: `ser_fifo_ctrl`

## Requirements
- R1: After reset, the parameter register reads both enables as 0 with the depth codes in bits [6:4] (transmit) and [2:0] (receive). The transmit watermark is 0 and the receive watermark is 1. Both counts are 0, the FIFO status register reads 0xC0, and the line status register reads 0xC0 while `tx_busy` and `rx_idle` are low.
- R2: Bits 7 (transmit) and 3 (receive) of the parameter register (offset 0x10) are writable queue enables. A queue whose enable is 0 holds at most one byte. An enabled queue holds 2^(code+1) bytes.
- R3: A write to the data register (offset 0x07) enters the transmit queue when the count, taken before any pop in the same cycle, is below the effective depth. Otherwise the byte is dropped and transmit-overflow (FIFO status bit 1) is set.
- R4: `tx_valid` is high exactly when the transmit count (offset 0x14) is non-zero. Bytes leave in write order, one on each edge with `tx_valid` and `tx_ready` both high.
- R5: Line status (offset 0x04) bit 7 is 1 when the transmit count is at or below the transmit watermark (offset 0x13). Bit 6 is 1 when the transmit queue is empty and `tx_busy` is low.
- R6: A received byte is taken on any edge with `rx_valid` high and room in the queue. With no room the byte is lost, and both line status bit 3 (overrun) and FIFO status bit 2 (receive overflow) are set.
- R7: Line status bit 5 is 1 when the receive count (offset 0x16) is at or above the receive watermark (offset 0x15). A data read returns the oldest byte and removes it. A data read while the queue is empty returns 0 and sets FIFO status bit 0 (receive underflow).
- R8: The error bits `rx_err` = {noise, framing, parity} are stored with each byte. They are ORed into line status bits 2, 1 and 0 from the cycle after that byte becomes the oldest entry.
- R9: Line status bits 3..0 are sticky. A data read clears exactly those bits that were 1 at the most recent line status read, provided no data read has come between the two. Any other access leaves them unchanged.
- R10: Writing 1 to FIFO control (offset 0x11) bit 7 or bit 6 empties the transmit or receive queue on that edge. A push in the same cycle is discarded. The flush bits read back 0, and the overflow flags are unchanged.
- R11: FIFO status (offset 0x12) bit 7 shows transmit empty and bit 6 shows receive empty. Bits 2..0 are cleared by writing 1 to them.
- R12: `fifo_irq` is the OR of FIFO status bits 2..0, each masked by the matching FIFO control enable bit 2..0.
- R13: Line status bit 4 follows the `rx_idle` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects happen on this edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_busy | input | 1 | Shifter is sending a frame |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | {noise, framing, parity} for this byte |
| rx_idle | input | 1 | Receive line idle indication |
| fifo_irq | output | 1 | Masked overflow/underflow interrupt |

## Verification
Two pairs of events can land in the same cycle. The first is a data-register write to a full transmit queue on the same edge that the shifter pops a byte. The bench forces this with a directed write while `tx_ready` is high. It expects the write to be dropped with the overflow flag set, and then, one cycle later, a write plus a pop that leaves the count unchanged. Random writes, count reads and random `tx_ready` are checked against a bench queue model. The second pair is a clearing data read on the same edge that a new byte with an error bit becomes the oldest entry. Here the bench expects the flag for that new byte to appear only afterwards and not to be lost. A flush on the same edge as a receive push is also checked, and the push must be discarded.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [5:0] A_STAT  = 6'h04;
  localparam logic [5:0] A_DATA  = 6'h07;
  localparam logic [5:0] A_PARAM = 6'h10;
  localparam logic [5:0] A_CTRL  = 6'h11;
  localparam logic [5:0] A_FSTAT = 6'h12;
  localparam logic [5:0] A_TXWM  = 6'h13;
  localparam logic [5:0] A_TXCNT = 6'h14;
  localparam logic [5:0] A_RXWM  = 6'h15;
  localparam logic [5:0] A_RXCNT = 6'h16;
  localparam int ERRW = 3;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic         one_deep,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [AW:0]  count,
  output logic         full,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = one_deep ? !empty : (count == (AW+1)'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  // R10: a flush leaves the queue empty on the next cycle
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R3: a full queue that is not drained keeps its count
  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> (count == $past(count)));
  // R2: never more than the physical depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/sfc_err_track.sv
module sfc_err_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       snap,
  input  logic       clr,
  input  logic       head_valid,
  input  logic [2:0] head_err,
  input  logic       ovr_set,
  output logic [3:0] flags
);
  logic [3:0] mask_q;
  logic [3:0] hd;

  assign hd = {1'b0, head_valid ? head_err : 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      mask_q <= '0;
    end else begin
      flags <= ((flags | hd) & ~(clr ? mask_q : 4'b0)) | {ovr_set, 3'b000};
      if (snap)     mask_q <= flags;
      else if (clr) mask_q <= '0;
    end
  end

  // R9: without a data read no flag drops
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(flags) & ~flags) == 4'b0));
  // R8: error bits of the oldest entry show up one cycle later
  p_head_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !clr) |=> ((flags[2:0] & $past(head_err)) == $past(head_err)));
endmodule

// File: rtl/ser_fifo_ctrl.sv
module ser_fifo_ctrl
  import sfc_pkg::*;
#(
  parameter int TX_CODE = 2,
  parameter int RX_CODE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  input  logic       tx_busy,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic [2:0] rx_err,
  input  logic       rx_idle,
  output logic       fifo_irq
);
  localparam int TAW = TX_CODE + 1;
  localparam int RAW = RX_CODE + 1;
  localparam int RW  = 8 + ERRW;

  logic          tx_en_q, rx_en_q;
  logic [2:0]    ie_q, ovf_q;
  logic [7:0]    txwm_q, rxwm_q;
  logic [TAW:0]  tx_cnt;
  logic [RAW:0]  rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [RW-1:0] rx_head;
  logic [3:0]    flags;
  logic [7:0]    stat, fstat;
  logic          wr_data, rd_data, rd_stat, wr_ctrl;
  logic          tx_drop, rx_ovr, rx_uf, tx_flush, rx_flush;

  assign wr_data  = bus_wr && bus_addr == A_DATA;
  assign rd_data  = bus_rd && bus_addr == A_DATA;
  assign rd_stat  = bus_rd && bus_addr == A_STAT;
  assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  assign tx_flush = wr_ctrl && bus_wdata[7];
  assign rx_flush = wr_ctrl && bus_wdata[6];
  assign tx_drop  = wr_data && tx_full;
  assign rx_ovr   = rx_valid && rx_full;
  assign rx_uf    = rd_data && rx_empty;
  assign tx_valid = !tx_empty;

  sfc_fifo #(.W(8), .AW(TAW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(wr_data),
    .pop(tx_ready), .one_deep(!tx_en_q), .din(bus_wdata), .dout(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  sfc_fifo #(.W(RW), .AW(RAW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_valid),
    .pop(rd_data), .one_deep(!rx_en_q), .din({rx_err, rx_data}),
    .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  sfc_err_track u_err (
    .clk(clk), .rst_n(rst_n), .snap(rd_stat), .clr(rd_data),
    .head_valid(!rx_empty), .head_err(rx_head[RW-1:8]),
    .ovr_set(rx_ovr), .flags(flags));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      ie_q    <= '0;
      ovf_q   <= '0;
      txwm_q  <= 8'd0;
      rxwm_q  <= 8'd1;
    end else begin
      if (bus_wr && bus_addr == A_PARAM) begin
        tx_en_q <= bus_wdata[7];
        rx_en_q <= bus_wdata[3];
      end
      if (wr_ctrl) ie_q <= bus_wdata[2:0];
      if (bus_wr && bus_addr == A_TXWM) txwm_q <= bus_wdata;
      if (bus_wr && bus_addr == A_RXWM) rxwm_q <= bus_wdata;
      ovf_q <= (ovf_q & ~((bus_wr && bus_addr == A_FSTAT) ? bus_wdata[2:0] : 3'b0))
             | {rx_ovr, tx_drop, rx_uf};
    end
  end

  assign stat  = {8'(tx_cnt) <= txwm_q, tx_empty && !tx_busy,
                  8'(rx_cnt) >= rxwm_q, rx_idle, flags};
  assign fstat = {tx_empty, rx_empty, 3'b000, ovf_q};
  assign fifo_irq = |(ovf_q & ie_q);

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = stat;
      A_DATA:  bus_rdata = rx_empty ? 8'h00 : rx_head[7:0];
      A_PARAM: bus_rdata = {tx_en_q, 3'(TX_CODE), rx_en_q, 3'(RX_CODE)};
      A_CTRL:  bus_rdata = {5'b00000, ie_q};
      A_FSTAT: bus_rdata = fstat;
      A_TXWM:  bus_rdata = txwm_q;
      A_TXCNT: bus_rdata = 8'(tx_cnt);
      A_RXWM:  bus_rdata = rxwm_q;
      A_RXCNT: bus_rdata = 8'(rx_cnt);
      default: bus_rdata = 8'h00;
    endcase
  end

  // R7: an empty data read raises receive underflow
  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_empty) |=> ovf_q[0]);
  // R3: a write into a full transmit queue raises transmit overflow
  p_txdrop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full) |=> ovf_q[1]);
  // R5: transmit complete never while bytes wait
  p_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !stat[6]);
  // R6: an overrun push sets both overrun indications
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |=> (flags[3] && ovf_q[2]));
endmodule

// File: tb/ser_fifo_ctrl_test.sv
module ser_fifo_ctrl_test;
  logic       clk = 0, rst_n = 0;
  logic [5:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       tx_valid, tx_ready = 0, tx_busy = 0;
  logic [7:0] tx_data;
  logic       rx_valid = 0, rx_idle = 0;
  logic [7:0] rx_data = 0;
  logic [2:0] rx_err = 0;
  logic       fifo_irq;
  int n_chk = 0, n_bad = 0;
  logic [7:0] d;
  byte unsigned q[$];

  ser_fifo_ctrl uut (.*);

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_stat(int txc, int txwm, bit busy,
      int rxc, int rxwm, bit idle, logic [3:0] fl);
    return {txc <= txwm, txc == 0 && !busy, rxc >= rxwm, idle, fl};
  endfunction
  function automatic logic [7:0] exp_fstat(int txc, int rxc, logic [2:0] f);
    return {txc == 0, rxc == 0, 3'b000, f};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask
  task automatic wr(logic [5:0] a, logic [7:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(logic [5:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic rchk(string req, logic [5:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v); chk(req, v, exp);
  endtask
  task automatic push(logic [7:0] v, logic [2:0] e);
    rx_valid = 1; rx_data = v; rx_err = e;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rchk("R1 param", 6'h10, 8'h22);
    rchk("R1 status", 6'h04, exp_stat(0, 0, 0, 0, 1, 0, 4'h0));
    rchk("R1 fstat", 6'h12, exp_fstat(0, 0, 3'b000));
    rchk("R1 rxwm", 6'h15, 8'h01);
    rchk("R1 txcnt", 6'h14, 8'h00);
    // R2/R3 disabled queue holds one byte
    wr(6'h07, 8'h11);
    wr(6'h07, 8'h22);
    rchk("R2 one-deep count", 6'h14, 8'h01);
    rchk("R3 drop flag", 6'h12, exp_fstat(1, 0, 3'b010));
    wr(6'h12, 8'h02);
    rchk("R11 w1c", 6'h12, exp_fstat(1, 0, 3'b000));
    tx_ready = 1; #1;
    chk("R4 first byte", tx_data, 8'h11);
    @(negedge clk); tx_ready = 0;
    chk("R4 valid drops", {7'b0, tx_valid}, 8'h00);
    // R2 enable queues
    wr(6'h10, 8'h88);
    rchk("R2 param rb", 6'h10, 8'hAA);
    for (int i = 0; i < 9; i++) wr(6'h07, 8'hA0 + 8'(i));
    rchk("R2 full depth", 6'h14, 8'h08);
    rchk("R3 overflow", 6'h12, exp_fstat(8, 0, 3'b010));
    rchk("R5 tdre low", 6'h04, exp_stat(8, 0, 0, 0, 1, 0, 4'h0));
    wr(6'h13, 8'h08);
    rchk("R5 tdre at wm", 6'h04, exp_stat(8, 8, 0, 0, 1, 0, 4'h0));
    wr(6'h11, 8'h02);
    chk("R12 irq on", {7'b0, fifo_irq}, 8'h01);
    rchk("R10 ctrl rb", 6'h11, 8'h02);
    wr(6'h12, 8'h02);
    chk("R12 irq off", {7'b0, fifo_irq}, 8'h00);
    tx_ready = 1;
    for (int i = 0; i < 8; i++) begin
      #1 chk("R4 order", tx_data, 8'hA0 + 8'(i));
      @(negedge clk);
    end
    tx_ready = 0; #1;
    chk("R4 drained", {7'b0, tx_valid}, 8'h00);
    tx_busy = 1;
    rchk("R5 tc busy", 6'h04, exp_stat(0, 8, 1, 0, 1, 0, 4'h0));
    tx_busy = 0;
    rchk("R5 tc done", 6'h04, exp_stat(0, 8, 0, 0, 1, 0, 4'h0));
    // R3 same-cycle write and pop on full queue
    for (int i = 0; i < 8; i++) wr(6'h07, 8'hB0 + 8'(i));
    tx_ready = 1; wr(6'h07, 8'hEE); tx_ready = 0;
    rchk("R3 full write+pop", 6'h14, 8'h07);
    rchk("R3 flag on same cycle", 6'h12, exp_fstat(7, 0, 3'b010));
    tx_ready = 1; wr(6'h07, 8'hEF); tx_ready = 0;
    rchk("R3 write+pop keeps", 6'h14, 8'h07);
    wr(6'h11, 8'h82);
    rchk("R10 tx flush", 6'h14, 8'h00);
    rchk("R10 flags kept", 6'h12, exp_fstat(0, 0, 3'b010));
    rchk("R10 flush rb0", 6'h11, 8'h02);
    wr(6'h12, 8'h07);
    // R8/R9 receive errors
    push(8'h31, 3'b000); push(8'h32, 3'b010); push(8'h33, 3'b001);
    rchk("R6 rxcnt", 6'h16, 8'h03);
    rchk("R7 rdrf", 6'h04, exp_stat(0, 8, 0, 3, 1, 0, 4'h0));
    rchk("R7 data0", 6'h07, 8'h31);
    @(negedge clk);
    rchk("R8 frame shown", 6'h04, exp_stat(0, 8, 0, 2, 1, 0, 4'h2));
    rchk("R9 data1", 6'h07, 8'h32);
    @(negedge clk);
    rchk("R9 unarmed read", 6'h07, 8'h33);
    rchk("R9 parity kept", 6'h04, exp_stat(0, 8, 0, 0, 1, 0, 4'h1));
    rchk("R7 empty read", 6'h07, 8'h00);
    rchk("R9 cleared", 6'h04, exp_stat(0, 8, 0, 0, 1, 0, 4'h0));
    rchk("R7 underflow", 6'h12, exp_fstat(0, 0, 3'b001));
    wr(6'h12, 8'h01);
    // R6 overflow
    for (int i = 0; i < 9; i++) push(8'h40 + 8'(i), 3'b000);
    rchk("R6 rx full", 6'h16, 8'h08);
    rchk("R6 overrun", 6'h04, exp_stat(0, 8, 0, 8, 1, 0, 4'h8));
    rchk("R6 rxof", 6'h12, exp_fstat(0, 8, 3'b100));
    wr(6'h15, 8'h09);
    rchk("R7 wm above", 6'h04, exp_stat(0, 8, 0, 8, 9, 0, 4'h8));
    rchk("R9 oldest", 6'h07, 8'h40);
    rchk("R9 overrun clr", 6'h04, exp_stat(0, 8, 0, 7, 9, 0, 4'h0));
    wr(6'h11, 8'h42);
    rchk("R10 rx flush", 6'h16, 8'h00);
    rchk("R10 rxof kept", 6'h12, exp_fstat(0, 0, 3'b100));
    wr(6'h12, 8'h04);
    wr(6'h15, 8'h01);
    rx_valid = 1; rx_data = 8'h55; wr(6'h11, 8'h42); rx_valid = 0;
    rchk("R10 flush beats push", 6'h16, 8'h00);
    rx_idle = 1;
    rchk("R13 idle", 6'h04, exp_stat(0, 8, 0, 0, 1, 1, 4'h0));
    rx_idle = 0;
    // R3/R4 random transmit traffic against queue model
    for (int c = 0; c < 3000; c++) begin
      int act;
      bit acc, popd;
      act = int'($urandom % 6);
      tx_ready = 1'($urandom % 2);
      bus_wdata = 8'($urandom);
      bus_addr = (act == 3) ? 6'h14 : 6'h07;
      bus_wr = (act < 3);
      bus_rd = (act == 3);
      #1;
      if (tx_valid !== (q.size() > 0)) begin
        chk("R4 valid model", {7'b0, tx_valid}, {7'b0, q.size() > 0});
      end
      popd = tx_ready && q.size() > 0;
      if (popd) chk("R4 random order", tx_data, q[0]);
      if (act == 3) chk("R3 random count", bus_rdata, 8'(q.size()));
      acc = (act < 3) && q.size() < 8;
      if (popd) void'(q.pop_front());
      if (acc) q.push_back(bus_wdata);
      @(negedge clk);
      bus_wr = 0; bus_rd = 0;
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule